// File: doc/BRIEF.md
# Chainable SPI Duty-Code Slave

This block is the serial front end of a multi-channel low-side driver. A host drives chip select, serial clock and serial data. For each frame the block returns a 16-bit parallel status word and receives four 4-bit duty codes. The status word is captured when chip select falls and leaves most significant bit first, one bit per rising serial clock edge. Incoming data bits are taken on falling serial clock edges.

When chip select rises, the received word moves into the duty register, but only if the frame carried a whole, nonzero number of 16-bit words. Any other frame length leaves the previous duty codes in place. Received data passes through the shift register to the serial output, so identical devices can be chained into 32-bit or longer frames. In a chain, each device keeps the last 16 bits it saw.

All serial pins are synchronised into the system clock domain and their edges are detected there. The system clock must run well above the serial clock, which is at most 2 MHz. From a pin edge to the matching register update takes at most four system clocks.

Top module: `spi_duty_slave`

## Requirements
- R1: After reset, duty_o is 0 and sdo_oe_o is 0.
- R2: sdo_oe_o is 1 while a frame is active, which starts when chip select goes low. It returns to 0 after chip select goes high.
- R3: The status word is captured at the chip select falling edge. The first 16 serial clock rising edges then present its bits on sdo_o in the order bit 15, 14, …, 0.
- R4: sdi_i is sampled on serial clock falling edges and shifted in at bit 0. After 16 clocks, the first bit received sits at bit 15 of the committed word.
- R5: On the chip select rising edge, the received word is copied to duty_o if the frame's serial clock count is 16·n with n ≥ 1. Counts of 32 and above are included.
- R6: For a count of 0 or any count that is not a multiple of 16, duty_o keeps its previous value.
- R7: From the 17th rising edge onward, sdo_o repeats the sdi_i bit sampled 16 clocks earlier. This is the chaining pass-through.
- R8: Serial clock and data activity while chip select is high changes neither duty_o nor sdo_oe_o.
- R9: duty_o[4k+3:4k] is the duty code of channel k+1 (k = 0..3), least significant bit at the lowest index.
- R10: Changes on status_i after the chip select falling edge do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data in |
| status_i | input | 16 | Parallel status word to report |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| duty_o | output | 16 | Committed duty codes, four 4-bit channels |

## Verification
The bench applies frames of exactly 16 and 32 clocks. These distinguish a normal single-device commit from a chained frame, where the output must replay received bits and the last 16 bits win. Frames of 0, 15, 17 and random lengths separate the frame-length filter from the commit path. Two directed cases test routing: a one-hot first bit confirms shift direction, and a distinct code per nibble pins down channel placement. Serial clock activity with chip select high, and a status change in mid-frame, show that idle activity and late status writes cannot leak into outputs.

// File: rtl/spi_duty_pkg.sv
package spi_duty_pkg;
  localparam int unsigned FRAME_W_DEF = 16;
  localparam int unsigned CH_N_DEF    = 4;
  localparam int unsigned CODE_W_DEF  = 4;
  localparam int unsigned SYNC_N_DEF  = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= pin_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
  import spi_duty_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_s_i,
  input  logic               sclk_s_i,
  input  logic               sdi_s_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               active_o,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic               cs_n_d, sclk_d;
  logic [FRAME_W-1:0] shreg_q;
  logic               sdo_q, active_q, wrapped_q;
  logic [CNT_W-1:0]   cnt_q;
  edge_t              cs_e, sclk_e;
  logic               last_bit;

  assign cs_e.fall   = cs_n_d & ~cs_n_s_i;
  assign cs_e.rise   = ~cs_n_d & cs_n_s_i;
  assign sclk_e.rise = ~sclk_d & sclk_s_i;
  assign sclk_e.fall = sclk_d & ~sclk_s_i;
  assign last_bit    = (cnt_q == CNT_W'(FRAME_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_d    <= 1'b1;
      sclk_d    <= 1'b0;
      shreg_q   <= '0;
      sdo_q     <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s_i;
      sclk_d <= sclk_s_i;
      if (cs_e.fall) begin
        shreg_q   <= status_i;
        sdo_q     <= 1'b0;
        active_q  <= 1'b1;
        cnt_q     <= '0;
        wrapped_q <= 1'b0;
      end else if (cs_e.rise) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (sclk_e.rise) sdo_q <= shreg_q[FRAME_W-1];
        if (sclk_e.fall) begin
          shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s_i};
          cnt_q   <= last_bit ? '0 : cnt_q + CNT_W'(1);
          if (last_bit) wrapped_q <= 1'b1;
        end
      end
    end
  end

  // whole nonzero number of words only
  assign commit_o = cs_e.rise & active_q & wrapped_q & (cnt_q == '0);
  assign sdo_o    = sdo_q;
  assign active_o = active_q;
  assign frame_o  = shreg_q;

  p_oe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_e.rise |=> !active_q);
  p_oe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_e.fall |=> active_q);
  p_sdo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_e.rise && !cs_e.fall) |=> $stable(sdo_q));
  p_idle_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !cs_e.fall) |=> $stable(shreg_q));
  p_commit_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> cs_e.rise);
endmodule

// File: rtl/spi_duty_bank.sv
module spi_duty_bank
  import spi_duty_pkg::*;
#(
  parameter int unsigned CH_N   = CH_N_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  localparam int unsigned BANK_W = CH_N * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [BANK_W-1:0] frame_i,
  output logic [BANK_W-1:0] duty_o
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       code_q <= '0;
      else if (commit_i) code_q <= frame_i[c*CODE_W +: CODE_W];
    end
    assign duty_o[c*CODE_W +: CODE_W] = code_q;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(duty_o));
  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (duty_o == $past(frame_i)));
endmodule

// File: rtl/spi_duty_slave.sv
module spi_duty_slave
  import spi_duty_pkg::*;
#(
  parameter int unsigned CH_N   = CH_N_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF,
  localparam int unsigned FRAME_W = CH_N * CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [FRAME_W-1:0] duty_o
);
  logic [2:0]         pins_s;
  logic               commit;
  logic [FRAME_W-1:0] frame;

  spi_pin_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({cs_ni, sclk_i, sdi_i}),
    .lvl_o (pins_s)
  );

  spi_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_s_i(pins_s[2]),
    .sclk_s_i(pins_s[1]),
    .sdi_s_i (pins_s[0]),
    .status_i(status_i),
    .sdo_o   (sdo_o),
    .active_o(sdo_oe_o),
    .commit_o(commit),
    .frame_o (frame)
  );

  spi_duty_bank #(.CH_N(CH_N), .CODE_W(CODE_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .frame_i (frame),
    .duty_o  (duty_o)
  );

  p_idle_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sdo_oe_o && pins_s[2]) |=> !sdo_oe_o);
endmodule

// File: tb/spi_duty_slave_bench.sv
module spi_duty_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] status = '0;
  logic        sdo, sdo_oe;
  logic [15:0] duty;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] exp_duty = '0;

  always #2 clk = ~clk;

  spi_duty_slave u_spi_duty_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .status_i(status), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .duty_o(duty)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit len_ok(input int nb);
    return (nb > 0) && (nb % 16 == 0);
  endfunction

  task automatic run_frame(input int nb, input logic [15:0] st,
                           input logic [63:0] dat, input bit chg);
    logic [15:0] model;
    status = st;
    cs_n = 1'b0;
    wt(8);
    chk("R2 oe on", {15'b0, sdo_oe}, 16'h0001);
    if (chg) status = ~st;  // R10
    model = st;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1;
      sdi  = dat[i];
      wt(7);
      if (i < 16) chk(chg ? "R10 sdo" : "R3 sdo", {15'b0, sdo}, {15'b0, model[15]});
      else        chk("R7 pass", {15'b0, sdo}, {15'b0, model[15]});
      wt(1);
      sclk = 1'b0;
      wt(8);
      model = {model[14:0], dat[i]};
    end
    cs_n = 1'b1;
    wt(8);
    if (len_ok(nb)) exp_duty = model;
    chk(len_ok(nb) ? "R5 commit" : "R6 keep", duty, exp_duty);
    chk("R2 oe off", {15'b0, sdo_oe}, 16'h0000);
  endtask

  function automatic logic [63:0] word_bits(input logic [15:0] w);
    logic [63:0] r = '0;
    for (int i = 0; i < 16; i++) r[i] = w[15-i];
    return r;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    wt(3);
    rst_n = 1'b1;
    wt(4);
    chk("R1 duty", duty, 16'h0000);
    chk("R1 oe", {15'b0, sdo_oe}, 16'h0000);

    // R4: first bit lands at bit 15
    run_frame(16, 16'hA5C3, 64'h1, 1'b0);
    chk("R4 first bit", duty, 16'h8000);

    // R9: nibble placement
    run_frame(16, 16'h3C0F, word_bits(16'h4321), 1'b0);
    chk("R9 ch1", {12'b0, duty[3:0]},   16'h0001);
    chk("R9 ch2", {12'b0, duty[7:4]},   16'h0002);
    chk("R9 ch3", {12'b0, duty[11:8]},  16'h0003);
    chk("R9 ch4", {12'b0, duty[15:12]}, 16'h0004);

    // R6: bad lengths
    run_frame(15, 16'hFFFF, 64'hFFFF_FFFF, 1'b0);
    run_frame(17, 16'h0000, 64'h1_5555, 1'b0);
    run_frame(0,  16'h1234, 64'h0, 1'b0);
    chk("R6 kept", duty, 16'h4321);

    // R7/R5: chained 32-bit frame
    run_frame(32, 16'h9E71, {32'h0, word_bits(16'hBEEF), word_bits(16'h1357)} , 1'b0);

    // R10: status changes mid-frame
    run_frame(16, 16'h6A0D, word_bits(16'h2468), 1'b1);

    // R8: activity with chip select high
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b1; sdi = i[0]; wt(8);
      sclk = 1'b0; wt(8);
    end
    chk("R8 duty", duty, exp_duty);
    chk("R8 oe", {15'b0, sdo_oe}, 16'h0000);
    run_frame(16, 16'hC001, word_bits(16'h0F0F), 1'b0);

    for (int k = 0; k < 24; k++) begin
      int nb;
      logic [63:0] d;
      nb = ($urandom % 3 == 0) ? 16 * (1 + $urandom % 3) : int'($urandom % 49);
      d  = {$urandom, $urandom};
      run_frame(nb, 16'($urandom), d, 1'($urandom % 4 == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule